// File: doc/BRIEF.md
# Duty-Shaped Waveform Table Builder

This block computes one period of a square, sawtooth or triangle wave and writes it, one sample at a time, into an external sample memory through a simple write port. A duty-cycle percentage sets a split index that divides the period into two segments. Each segment is scaled over its own length, so the same shape can be made lopsided. Every level is clamped between a lower and an upper voltage limit. The level is then converted into a left-aligned 10-bit converter code against a full-scale voltage. After the 128 waveform points, one more entry holds the clamped offset. A player can park the output on that rest level when playback stops.

All voltages are unsigned integers in one common unit, for example millivolts. A one-cycle start pulse captures the settings. A sequential divider scales each point and then converts it to a code, so one entry is written about every fifty cycles. A one-cycle done pulse follows the last write.

Top module: `wave_table_builder`

## Requirements
- R1: The split index is s = d*128/100, truncated, where d is the duty input with any value above 100 treated as 100.
- R2: The shape code selects the wave: 0 and 3 give a square wave, 1 gives a sawtooth and 2 gives a triangle. In the square wave, point x < s takes offset+h and every other point takes offset-h, where h = amplitude/2 truncated.
- R3: In the sawtooth, point x < s is offset-h+(h*x)/s, and point x >= s is offset+(h*(x-s))/(128-s). All divisions truncate.
- R4: In the triangle, with q1 = s/2 and q3 = s+(128-s)/2, the point is one of four values, chosen by where x falls. Below q1 it is offset+(h*x)/q1. From q1 up to s it is amplitude+offset-(h*x)/q1. From s up to q3 it is offset-(amplitude*(x-s))/(128-s). From q3 on it is offset-amplitude+(amplitude*(x-s))/(128-s).
- R5: Any scaling quotient whose divisor is zero counts as 0. This covers duty 0 or 100 and a split index of 1.
- R6: Each level v is clamped: if v < vmin the level is vmin, otherwise if v > vmax it is vmax.
- R7: Address 128 always receives the clamped offset level.
- R8: The code is floor(v*1023/vfull), limited to 1023, and is 0 when vfull is 0. The written 16-bit word is the code shifted left by 6, so bits 5:0 are always zero.
- R9: One build issues exactly 129 single-cycle writes, at addresses 0 to 128 in ascending order.
- R10: `done` is high for exactly one cycle, in the cycle right after the write to address 128.
- R11: A start pulse during a build is ignored. That build keeps the settings captured at its own start.
- R12: While reset is high, and in the cycle after it, `wr_en` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a build |
| shape | input | 2 | Wave select (0/3 square, 1 sawtooth, 2 triangle) |
| duty | input | 7 | Duty percentage, 0 to 100 |
| amp | input | 12 | Peak-to-peak amplitude |
| offset | input | 12 | Centre level |
| vmin | input | 12 | Lower clamp limit |
| vmax | input | 12 | Upper clamp limit |
| vfull | input | 12 | Voltage that maps to code 1023 |
| wr_en | output | 1 | Sample write strobe |
| wr_addr | output | 8 | Sample address, 0 to 128 |
| wr_data | output | 16 | Left-aligned converter code |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: 128 points, 12-bit voltages and a 22-bit divider. Twelve-bit voltages are wide enough that amplitude plus offset can run past the upper limit and offset minus half the amplitude can go below zero, so both clamp branches are reached. A full scale below the clamp limit pushes the code into saturation, and a full scale of zero is also tried. Duties of 0, 1, 37, 100 and 120 percent cover the empty segments, the zero first-quarter divisor, an odd split index and the duty limit.

// File: rtl/wtb_pkg.sv
package wtb_pkg;
  typedef enum logic [1:0] {
    SH_SQUARE = 2'd0,
    SH_SAW    = 2'd1,
    SH_TRI    = 2'd2,
    SH_SQ_ALT = 2'd3
  } shape_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SPLIT, ST_LOAD, ST_SCALE, ST_CODE, ST_CONV, ST_FIN
  } st_e;
endpackage

// File: rtl/wtb_divider.sv
module wtb_divider #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         fin,
  output logic [W-1:0] quot
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  rem;
  logic [W-1:0]  q;
  logic [W-1:0]  d;
  logic          run;
  logic [W:0]    rem_sh;

  assign rem_sh = {rem, q[W-1]};
  assign quot   = (d == '0) ? '0 : q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      rem <= '0;
      q   <= '0;
      d   <= '0;
      run <= 1'b0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        q   <= num;
        d   <= den;
        rem <= '0;
        cnt <= CW'(W);
        run <= 1'b1;
      end else if (run) begin
        if (rem_sh >= {1'b0, d}) begin
          rem <= W'(rem_sh - {1'b0, d});
          q   <= {q[W-2:0], 1'b1};
        end else begin
          rem <= W'(rem_sh);
          q   <= {q[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wtb_point_gen.sv
module wtb_point_gen
  import wtb_pkg::*;
#(
  parameter int NPTS = 128,
  parameter int VW   = 12,
  parameter int AW   = 8,
  parameter int SW   = 15,
  parameter int DW   = 22
) (
  input  shape_e              shape,
  input  logic [AW-1:0]       x,
  input  logic [AW-1:0]       split,
  input  logic [VW-1:0]       amp,
  input  logic [VW-1:0]       offset,
  output logic signed [SW-1:0] base,
  output logic                sub,
  output logic [DW-1:0]       num,
  output logic [DW-1:0]       den
);
  logic [VW-1:0]        half;
  logic [AW-1:0]        q1, q3, tail;
  logic signed [SW-1:0] off_s, amp_s, half_s;
  logic [DW-1:0]        k_lo, k_hi;

  assign half   = amp >> 1;
  assign tail   = AW'(NPTS) - split;
  assign q1     = split >> 1;
  assign q3     = split + (tail >> 1);
  assign off_s  = $signed({{(SW-VW){1'b0}}, offset});
  assign amp_s  = $signed({{(SW-VW){1'b0}}, amp});
  assign half_s = $signed({{(SW-VW){1'b0}}, half});
  assign k_lo   = DW'(x);
  assign k_hi   = DW'(x - split);

  always_comb begin
    base = off_s;
    sub  = 1'b0;
    num  = '0;
    den  = DW'(1);
    if (x == AW'(NPTS)) begin
      base = off_s;
    end else begin
      unique case (shape)
        SH_SAW: begin
          if (x < split) begin
            base = off_s - half_s;
            num  = DW'(half) * k_lo;
            den  = DW'(split);
          end else begin
            num  = DW'(half) * k_hi;
            den  = DW'(tail);
          end
        end
        SH_TRI: begin
          if (x < q1) begin
            num  = DW'(half) * k_lo;
            den  = DW'(q1);
          end else if (x < split) begin
            base = amp_s + off_s;
            sub  = 1'b1;
            num  = DW'(half) * k_lo;
            den  = DW'(q1);
          end else if (x < q3) begin
            sub  = 1'b1;
            num  = DW'(amp) * k_hi;
            den  = DW'(tail);
          end else begin
            base = off_s - amp_s;
            num  = DW'(amp) * k_hi;
            den  = DW'(tail);
          end
        end
        default: begin
          base = (x < split) ? off_s + half_s : off_s - half_s;
        end
      endcase
    end
  end
endmodule

// File: rtl/wave_table_builder.sv
module wave_table_builder
  import wtb_pkg::*;
#(
  parameter int NPTS   = 128,
  parameter int VW     = 12,
  parameter int DUW    = 7,
  parameter int CODEW  = 10,
  parameter int CSHIFT = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [1:0]                shape,
  input  logic [DUW-1:0]            duty,
  input  logic [VW-1:0]             amp,
  input  logic [VW-1:0]             offset,
  input  logic [VW-1:0]             vmin,
  input  logic [VW-1:0]             vmax,
  input  logic [VW-1:0]             vfull,
  output logic                      wr_en,
  output logic [$clog2(NPTS+1)-1:0] wr_addr,
  output logic [CODEW+CSHIFT-1:0]   wr_data,
  output logic                      done
);
  localparam int AW       = $clog2(NPTS + 1);
  localparam int SW       = VW + 3;
  localparam int DW       = VW + CODEW;
  localparam int PW       = DUW + AW;
  localparam int PCT      = 100;
  localparam int CODE_MAX = (1 << CODEW) - 1;

  st_e            st;
  shape_e         shape_r;
  logic [DUW-1:0] duty_r;
  logic [VW-1:0]  amp_r, off_r, vmin_r, vmax_r, vfull_r, vc_r;
  logic [AW-1:0]  split_r, x_r;

  logic [DUW-1:0] duty_c;
  logic [PW-1:0]  split_prod;
  logic [AW-1:0]  split_calc;

  logic signed [SW-1:0] pg_base;
  logic                 pg_sub;
  logic [DW-1:0]        pg_num, pg_den;

  logic          div_go, div_fin;
  logic [DW-1:0] div_num, div_den, div_quot;

  logic signed [SW-1:0] quot_s, v_raw, lo_s, hi_s;
  logic [VW-1:0]        v_cl;
  logic [CODEW-1:0]     code;

  // duty is limited to 100 percent before the split is taken
  assign duty_c     = (duty_r > DUW'(PCT)) ? DUW'(PCT) : duty_r;
  assign split_prod = PW'(duty_c) * PW'(NPTS);
  assign split_calc = AW'(split_prod / PW'(PCT));

  wtb_point_gen #(
    .NPTS(NPTS), .VW(VW), .AW(AW), .SW(SW), .DW(DW)
  ) u_pg (
    .shape  (shape_r),
    .x      (x_r),
    .split  (split_r),
    .amp    (amp_r),
    .offset (off_r),
    .base   (pg_base),
    .sub    (pg_sub),
    .num    (pg_num),
    .den    (pg_den)
  );

  wtb_divider #(.W(DW)) u_div (
    .clk  (clk),
    .rst  (rst),
    .go   (div_go),
    .num  (div_num),
    .den  (div_den),
    .fin  (div_fin),
    .quot (div_quot)
  );

  assign quot_s = $signed(SW'(div_quot));
  assign v_raw  = pg_sub ? (pg_base - quot_s) : (pg_base + quot_s);
  assign lo_s   = $signed({{(SW-VW){1'b0}}, vmin_r});
  assign hi_s   = $signed({{(SW-VW){1'b0}}, vmax_r});

  always_comb begin
    if (v_raw < lo_s)      v_cl = vmin_r;
    else if (v_raw > hi_s) v_cl = vmax_r;
    else                   v_cl = VW'(v_raw);
  end

  assign code = (div_quot > DW'(CODE_MAX)) ? CODEW'(CODE_MAX) : CODEW'(div_quot);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      shape_r <= SH_SQUARE;
      duty_r  <= '0;
      amp_r   <= '0;
      off_r   <= '0;
      vmin_r  <= '0;
      vmax_r  <= '0;
      vfull_r <= '0;
      vc_r    <= '0;
      split_r <= '0;
      x_r     <= '0;
      div_go  <= 1'b0;
      div_num <= '0;
      div_den <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      done    <= 1'b0;
    end else begin
      wr_en  <= 1'b0;
      done   <= 1'b0;
      div_go <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            shape_r <= shape_e'(shape);
            duty_r  <= duty;
            amp_r   <= amp;
            off_r   <= offset;
            vmin_r  <= vmin;
            vmax_r  <= vmax;
            vfull_r <= vfull;
            st      <= ST_SPLIT;
          end
        end
        ST_SPLIT: begin
          split_r <= split_calc;
          x_r     <= '0;
          st      <= ST_LOAD;
        end
        ST_LOAD: begin
          div_go  <= 1'b1;
          div_num <= pg_num;
          div_den <= pg_den;
          st      <= ST_SCALE;
        end
        ST_SCALE: begin
          if (div_fin) begin
            vc_r <= v_cl;
            st   <= ST_CODE;
          end
        end
        ST_CODE: begin
          div_go  <= 1'b1;
          div_num <= DW'(vc_r) * DW'(CODE_MAX);
          div_den <= DW'(vfull_r);
          st      <= ST_CONV;
        end
        ST_CONV: begin
          if (div_fin) begin
            wr_en   <= 1'b1;
            wr_addr <= x_r;
            wr_data <= {code, {CSHIFT{1'b0}}};
            if (x_r == AW'(NPTS)) begin
              st <= ST_FIN;
            end else begin
              x_r <= x_r + 1'b1;
              st  <= ST_LOAD;
            end
          end
        end
        ST_FIN: begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wtb_checker.sv
module wtb_checker #(
  parameter int NPTS = 128,
  parameter int AW   = 8,
  parameter int DATW = 16,
  parameter int LOWB = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic [DATW-1:0] wr_data,
  input logic            done
);
  logic [AW-1:0] last_addr;
  logic          seen;
  logic [AW:0]   wcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_addr <= '0;
      seen      <= 1'b0;
      wcnt      <= '0;
    end else if (done) begin
      seen <= 1'b0;
      wcnt <= '0;
    end else if (wr_en) begin
      last_addr <= wr_addr;
      seen      <= (wr_addr != AW'(NPTS));
      wcnt      <= wcnt + 1'b1;
    end
  end

  // R9
  first_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !seen) |-> (wr_addr == '0));
  // R9
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && seen) |-> (wr_addr == last_addr + 1'b1));
  // R9
  write_single_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
  // R8
  low_bits_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ((wr_data & DATW'((1 << LOWB) - 1)) == '0));
  // R10
  done_follow_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(wr_en) && ($past(wr_addr) == AW'(NPTS))));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R11
  write_count_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (wcnt == (AW+1)'(NPTS + 1)));
  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!wr_en && !done));
endmodule

bind wave_table_builder wtb_checker #(
  .NPTS(NPTS), .AW($clog2(NPTS+1)), .DATW(CODEW+CSHIFT), .LOWB(CSHIFT)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .done    (done)
);

// File: tb/wave_table_builder_test.sv
`timescale 1ns/1ps
module wave_table_builder_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  shape = '0;
  logic [6:0]  duty = '0;
  logic [11:0] amp = '0, offset = '0, vmin = '0, vmax = '0, vfull = '0;
  logic        wr_en, done;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int wcount = 0;
  int ndone = 0;
  int last_cyc = 0;
  int done_cyc = 0;
  bit finished = 0;
  string cur_tag = "";
  int exp_addr[$];
  int exp_data[$];
  string exp_tag[$];

  always #2 clk = ~clk;

  wave_table_builder uut (
    .clk(clk), .rst(rst), .start(start), .shape(shape), .duty(duty),
    .amp(amp), .offset(offset), .vmin(vmin), .vmax(vmax), .vfull(vfull),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  function automatic int qd(int a, int b);
    return (b == 0) ? 0 : a / b;   // R5
  endfunction

  function automatic int exp_word(int shp, int dty, int a, int off,
                                  int lo, int hi, int fs, int x);
    int d, s, h, q1, q3, v, c;
    d  = (dty > 100) ? 100 : dty;      // R1
    s  = d * 128 / 100;
    h  = a / 2;
    q1 = s / 2;
    q3 = s + (128 - s) / 2;
    if (x == 128) v = off;             // R7
    else if (shp == 1)                 // R3
      v = (x < s) ? off - h + qd(h * x, s) : off + qd(h * (x - s), 128 - s);
    else if (shp == 2) begin           // R4
      if (x < q1)      v = off + qd(h * x, q1);
      else if (x < s)  v = a + off - qd(h * x, q1);
      else if (x < q3) v = off - qd(a * (x - s), 128 - s);
      else             v = off - a + qd(a * (x - s), 128 - s);
    end else                           // R2
      v = (x < s) ? off + h : off - h;
    if (v < lo) v = lo;                // R6
    else if (v > hi) v = hi;
    c = (fs == 0) ? 0 : v * 1023 / fs; // R8
    if (c > 1023) c = 1023;
    return c * 64;
  endfunction

  task automatic check(string tag, int act, int expv, string what);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // monitor: scoreboard side
  always @(negedge clk) begin
    cyc++;
    if (wr_en) begin
      wcount++;
      if (exp_addr.size() == 0) begin
        check("R11", int'(wr_addr), -1, "write with nothing expected");
      end else begin
        int ea, ed;
        string et;
        ea = exp_addr.pop_front();
        ed = exp_data.pop_front();
        et = exp_tag.pop_front();
        check("R9", int'(wr_addr), ea, "write address");
        check(et, int'(wr_data), ed, $sformatf("data at %0d", ea));
      end
      if (wr_addr == 8'd128) last_cyc = cyc;
    end
    if (done) begin
      ndone++;
      done_cyc = cyc;
    end
  end

  // driver: pushes the expected table, then starts a build
  task automatic build(string tag, int shp, int dty, int a, int off,
                       int lo, int hi, int fs, bit poke);
    int w0, d0;
    for (int x = 0; x <= 128; x++) begin
      exp_addr.push_back(x);
      exp_data.push_back(exp_word(shp, dty, a, off, lo, hi, fs, x));
      exp_tag.push_back((x == 128) ? "R7" : tag);
    end
    w0 = wcount;
    d0 = ndone;
    @(negedge clk);
    shape = 2'(shp); duty = 7'(dty); amp = 12'(a); offset = 12'(off);
    vmin = 12'(lo); vmax = 12'(hi); vfull = 12'(fs);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (400) @(negedge clk);
      shape = 2'd2; duty = 7'd10; amp = 12'd4000; offset = 12'd100;  // R11
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (ndone == d0 && !finished) @(negedge clk);
    @(negedge clk);
    check("R10", done_cyc, last_cyc + 1, "done cycle vs last write");
    check("R9", wcount - w0, 129, "writes per build");
    repeat (60) @(negedge clk);
    check("R11", wcount - w0, 129, "writes after done");
    check("R10", ndone - d0, 1, "done pulses");
    check("R9", exp_addr.size(), 0, "entries left in scoreboard");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL R10 watchdog: actual=no done expected=done pulse");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12", int'(wr_en), 0, "wr_en in reset");
    check("R12", int'(done), 0, "done in reset");
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12", int'(wr_en), 0, "wr_en after reset");
    check("R12", int'(done), 0, "done after reset");

    build("R2", 0, 50, 2000, 1500, 0, 4095, 3300, 0);
    build("R3", 1, 25, 1600, 2000, 0, 4095, 3300, 0);
    build("R4", 2, 50, 2400, 2000, 0, 4095, 3300, 0);
    build("R4", 2, 37, 1001, 1700, 0, 4095, 3000, 0);
    build("R5", 2, 1, 1200, 1800, 0, 4095, 3300, 0);
    build("R5", 1, 0, 1500, 1600, 0, 4095, 3300, 0);
    build("R5", 1, 100, 1500, 1600, 0, 4095, 3300, 0);
    build("R1", 0, 120, 1000, 1500, 0, 4095, 3300, 0);
    build("R6", 2, 60, 4000, 1000, 300, 2500, 3300, 0);
    build("R8", 0, 40, 3000, 2000, 0, 4095, 1000, 0);
    build("R8", 1, 70, 1000, 1000, 0, 4095, 0, 0);
    build("R11", 3, 30, 1800, 1400, 200, 3900, 3300, 1);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule